// File: doc/BRIEF.md
# Pin Driver Group with Register Preload and Observe Test Control

This block sits between a group of eight logic cells and their package pins. It does two jobs. In normal operation it passes each cell output to its pin. It also decides whether each three-state driver is enabled, using a per-pin two-bit code. That code selects permanently off, permanently on, or one of two enable terms that all pins of the group share.

A small test controller adds two maintenance modes that a tester can request.

- **Preload** releases all pin drivers so the tester can drive the pins. It captures the pin values and then writes them, with a one-cycle strobe, into one bank of cell registers chosen by a bank select.
- **Observe** turns every driver on and routes the stored value of one register bank to the pins. That bank can be the output registers (bank 0) or one of the buried banks, which have no pin of their own.

While either mode is active the block raises a force signal to the cells. That signal puts combinatorial cells into registered mode and clears their product terms. The block also defers a preload while the cells' asynchronous initialization terms are active, so that the write is not overwritten at once.

The controller is a five-state machine:

| State | Meaning | Transitions |
|---|---|---|
| NORMAL | Normal operation | To PL_ARM on a preload request. Otherwise to OBSERVE on an observe request. |
| PL_ARM | Preload armed | Waits here while the init-busy input is high. Otherwise moves to PL_WRITE and captures pins and bank. |
| PL_WRITE | Strobe cycle | Always moves to PL_HOLD. |
| PL_HOLD | Preload done | Returns to NORMAL once the preload request drops. |
| OBSERVE | Observe mode | Returns to NORMAL once the observe request drops. |

Top module: `iogrp_test_ctl`

## Requirements
- R1: Outside test modes, a pin whose enable code (bits [2i+1:2i] of `oe_cfg`) is 0 has `pin_oe` low, and a pin whose code is 1 has `pin_oe` high, whatever the enable terms.
- R2: Outside test modes, enable code 2 makes `pin_oe` follow `oe_term[0]` and code 3 makes it follow `oe_term[1]`; both terms are shared by all pins.
- R3: Outside test modes, `pin_out` equals `mc_out` and `test_force` is low.
- R4: In every preload state `pin_oe` is all zero, and `test_force` is high in every preload and observe state.
- R5: A preload request seen in NORMAL moves to PL_ARM at the next edge. Leaving PL_ARM captures `pin_in` into `pl_data` and `bank_sel` into the target bank. In the cycle after that, exactly one bit of `pl_strobe` (bit = captured bank) is high, for one cycle only.
- R6: While `init_busy` is high the controller stays in PL_ARM and no strobe is issued.
- R7: After capture, `pl_data` does not change with later `pin_in` changes. Only one strobe is issued per request. The block returns to normal (`test_force` low) one edge after the request is released in PL_HOLD.
- R8: In OBSERVE, `pin_oe` is all ones regardless of `oe_cfg`. `pin_out` shows bits [8b+7:8b] of `reg_q` for the live `bank_sel` value b. Bank 0 is the output registers and higher banks are buried registers.
- R9: If preload and observe are both requested in NORMAL, preload wins.
- R10: After reset the controller is in NORMAL, `pl_strobe` is zero and `pl_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oe_cfg | input | 16 | Per-pin enable code, two bits per pin |
| oe_term | input | 2 | The two shared enable product terms |
| mc_out | input | 8 | Cell outputs for normal pin drive |
| reg_q | input | 16 | Stored register values, 8 bits per bank |
| pin_in | input | 8 | Values sensed on the pins |
| preload_req | input | 1 | Tester request for preload |
| observe_req | input | 1 | Tester request for observe |
| bank_sel | input | 1 | Register bank to preload or observe |
| init_busy | input | 1 | Asynchronous reset or preset term active |
| pin_out | output | 8 | Data to the pin drivers |
| pin_oe | output | 8 | Pin driver enables |
| pl_data | output | 8 | Captured preload data to the registers |
| pl_strobe | output | 2 | One-cycle preload write strobe per bank |
| test_force | output | 1 | Forces registered mode and clears product terms |

## Verification
The assertions take for granted that `bank_sel` only selects banks that exist. They also take for granted that `init_busy` reflects the cells' real initialization terms, so a strobe can be tied to a quiet previous cycle. The stimulus changes every input half a cycle away from the active edge. It uses only bank values 0 and 1 and holds each request until the controller has finished with it. A test therefore never starts while another is still pending.

// File: rtl/iogrp_pkg.sv
package iogrp_pkg;

    typedef enum logic [2:0] {
        TS_NORMAL   = 3'd0,
        TS_PL_ARM   = 3'd1,
        TS_PL_WRITE = 3'd2,
        TS_PL_HOLD  = 3'd3,
        TS_OBSERVE  = 3'd4
    } tctl_state_t;

    localparam logic [1:0] OE_OFF   = 2'd0;
    localparam logic [1:0] OE_ON    = 2'd1;
    localparam logic [1:0] OE_TERM0 = 2'd2;
    localparam logic [1:0] OE_TERM1 = 2'd3;

endpackage

// File: rtl/iogrp_oe_sel.sv
module iogrp_oe_sel #(
    parameter int N_PINS = 8
) (
    input  logic [2*N_PINS-1:0] cfg,
    input  logic [1:0]          term,
    output logic [N_PINS-1:0]   oe
);
    import iogrp_pkg::*;

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        logic [1:0] code;
        assign code = cfg[2*i +: 2];
        always_comb begin
            unique case (code)
                OE_OFF:   oe[i] = 1'b0;
                OE_ON:    oe[i] = 1'b1;
                OE_TERM0: oe[i] = term[0];
                OE_TERM1: oe[i] = term[1];
                default:  oe[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/iogrp_obs_mux.sv
module iogrp_obs_mux #(
    parameter int N_PINS  = 8,
    parameter int N_BANKS = 2,
    localparam int BANK_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
    input  logic [N_PINS*N_BANKS-1:0] reg_q,
    input  logic [BANK_W-1:0]         sel,
    output logic [N_PINS-1:0]         q
);
    always_comb begin
        q = '0;
        for (int b = 0; b < N_BANKS; b++) begin
            if (sel == BANK_W'(b)) begin
                q = reg_q[b*N_PINS +: N_PINS];
            end
        end
    end

endmodule

// File: rtl/iogrp_test_fsm.sv
module iogrp_test_fsm #(
    parameter int N_PINS  = 8,
    parameter int N_BANKS = 2,
    localparam int BANK_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                preload_req,
    input  logic                observe_req,
    input  logic                init_busy,
    input  logic [N_PINS-1:0]   pin_in,
    input  logic [BANK_W-1:0]   bank_sel,
    output logic                in_preload,
    output logic                in_observe,
    output logic [N_PINS-1:0]   pl_data,
    output logic [N_BANKS-1:0]  pl_strobe
);
    import iogrp_pkg::*;

    tctl_state_t state_q, state_d;
    logic [N_PINS-1:0] data_q;
    logic [BANK_W-1:0] bank_q;
    logic              capture;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_NORMAL: begin
                if (preload_req)      state_d = TS_PL_ARM;
                else if (observe_req) state_d = TS_OBSERVE;
            end
            TS_PL_ARM:   if (!init_busy)   state_d = TS_PL_WRITE;
            TS_PL_WRITE: state_d = TS_PL_HOLD;
            TS_PL_HOLD:  if (!preload_req) state_d = TS_NORMAL;
            TS_OBSERVE:  if (!observe_req) state_d = TS_NORMAL;
            default:     state_d = TS_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TS_NORMAL;
        else        state_q <= state_d;
    end

    assign capture = (state_q == TS_PL_ARM) && !init_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            bank_q <= '0;
        end else if (capture) begin
            data_q <= pin_in;
            bank_q <= bank_sel;
        end
    end

    always_comb begin
        in_preload = 1'b0;
        in_observe = 1'b0;
        pl_strobe  = '0;
        unique case (state_q)
            TS_NORMAL:  ;
            TS_PL_ARM:  in_preload = 1'b1;
            TS_PL_WRITE: begin
                in_preload = 1'b1;
                for (int b = 0; b < N_BANKS; b++) begin
                    if (bank_q == BANK_W'(b)) pl_strobe[b] = 1'b1;
                end
            end
            TS_PL_HOLD: in_preload = 1'b1;
            TS_OBSERVE: in_observe = 1'b1;
            default:    ;
        endcase
    end

    assign pl_data = data_q;

endmodule

// File: rtl/iogrp_test_ctl.sv
module iogrp_test_ctl #(
    parameter int N_PINS  = 8,
    parameter int N_BANKS = 2,
    localparam int BANK_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2*N_PINS-1:0]        oe_cfg,
    input  logic [1:0]                 oe_term,
    input  logic [N_PINS-1:0]          mc_out,
    input  logic [N_PINS*N_BANKS-1:0]  reg_q,
    input  logic [N_PINS-1:0]          pin_in,
    input  logic                       preload_req,
    input  logic                       observe_req,
    input  logic [BANK_W-1:0]          bank_sel,
    input  logic                       init_busy,
    output logic [N_PINS-1:0]          pin_out,
    output logic [N_PINS-1:0]          pin_oe,
    output logic [N_PINS-1:0]          pl_data,
    output logic [N_BANKS-1:0]         pl_strobe,
    output logic                       test_force
);
    logic [N_PINS-1:0] cfg_oe;
    logic [N_PINS-1:0] obs_q;
    logic              in_preload;
    logic              in_observe;

    iogrp_oe_sel #(.N_PINS(N_PINS)) u_oe_sel (
        .cfg  (oe_cfg),
        .term (oe_term),
        .oe   (cfg_oe)
    );

    iogrp_obs_mux #(.N_PINS(N_PINS), .N_BANKS(N_BANKS)) u_obs_mux (
        .reg_q (reg_q),
        .sel   (bank_sel),
        .q     (obs_q)
    );

    iogrp_test_fsm #(.N_PINS(N_PINS), .N_BANKS(N_BANKS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .preload_req (preload_req),
        .observe_req (observe_req),
        .init_busy   (init_busy),
        .pin_in      (pin_in),
        .bank_sel    (bank_sel),
        .in_preload  (in_preload),
        .in_observe  (in_observe),
        .pl_data     (pl_data),
        .pl_strobe   (pl_strobe)
    );

    always_comb begin
        if (in_observe) begin
            pin_oe  = '1;
            pin_out = obs_q;
        end else if (in_preload) begin
            pin_oe  = '0;
            pin_out = mc_out;
        end else begin
            pin_oe  = cfg_oe;
            pin_out = mc_out;
        end
    end

    assign test_force = in_preload | in_observe;

endmodule

// File: rtl/iogrp_test_ctl_chk.sv
module iogrp_test_ctl_chk #(
    parameter int N_PINS  = 8,
    parameter int N_BANKS = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [N_PINS-1:0]     mc_out,
    input logic                  init_busy,
    input logic [N_PINS-1:0]     pin_out,
    input logic [N_PINS-1:0]     pin_oe,
    input logic [N_BANKS-1:0]    pl_strobe,
    input logic                  test_force
);
    p_pass_through_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !test_force |-> (pin_out == mc_out));

    p_strobe_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_strobe != '0) |-> (pin_oe == '0) && test_force);

    p_strobe_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pl_strobe));

    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_strobe != '0) |=> (pl_strobe == '0));

    p_no_strobe_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_strobe != '0) |-> !$past(init_busy));

    p_observe_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (test_force && (pin_oe != '0)) |-> (pin_oe == '1));

endmodule

bind iogrp_test_ctl iogrp_test_ctl_chk #(.N_PINS(N_PINS), .N_BANKS(N_BANKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mc_out     (mc_out),
    .init_busy  (init_busy),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .pl_strobe  (pl_strobe),
    .test_force (test_force)
);

// File: tb/iogrp_test_ctl_bench.sv
module iogrp_test_ctl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] oe_cfg = '0;
    logic [1:0]  oe_term = '0;
    logic [7:0]  mc_out = '0;
    logic [15:0] reg_q = '0;
    logic [7:0]  pin_in = '0;
    logic        preload_req = 1'b0;
    logic        observe_req = 1'b0;
    logic [0:0]  bank_sel = '0;
    logic        init_busy = 1'b0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;
    logic [7:0]  pl_data;
    logic [1:0]  pl_strobe;
    logic        test_force;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    iogrp_test_ctl u_iogrp_test_ctl (
        .clk, .rst_n, .oe_cfg, .oe_term, .mc_out, .reg_q, .pin_in,
        .preload_req, .observe_req, .bank_sel, .init_busy,
        .pin_out, .pin_oe, .pl_data, .pl_strobe, .test_force
    );

    // {oe_cfg, oe_term, mc_out, expected pin_oe}
    localparam logic [33:0] VECS [8] = '{
        {16'h0000, 2'b11, 8'h12, 8'h00},
        {16'h5555, 2'b00, 8'h34, 8'hFF},
        {16'hAAAA, 2'b01, 8'h56, 8'hFF},
        {16'hAAAA, 2'b10, 8'h78, 8'h00},
        {16'hFFFF, 2'b10, 8'h9A, 8'hFF},
        {16'hFFFF, 2'b01, 8'hBC, 8'h00},
        {16'hE4E4, 2'b01, 8'hDE, 8'h66},
        {16'hE4E4, 2'b10, 8'hF0, 8'hAA}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R10: reset state
        chk("R10 strobe", 16'(pl_strobe), 16'h0);
        chk("R10 data", 16'(pl_data), 16'h0);
        chk("R10 force", 16'(test_force), 16'h0);
        rst_n = 1'b1;
        step();

        // R1 R2 R3: table of enable codes
        foreach (VECS[i]) begin
            {oe_cfg, oe_term, mc_out} = VECS[i][33:8];
            #1;
            chk((i < 2) ? "R1 oe" : "R2 oe", 16'(pin_oe), 16'(VECS[i][7:0]));
            chk("R3 out", 16'(pin_out), 16'(VECS[i][15:8]));
            chk("R3 force", 16'(test_force), 16'h0);
            step();
        end

        // R9: both requests; preload wins. R6: init_busy holds in PL_ARM
        oe_cfg = 16'h5555;
        pin_in = 8'h3C; bank_sel = 1'b1; init_busy = 1'b1;
        preload_req = 1'b1; observe_req = 1'b1;
        step();
        chk("R9 oe released", 16'(pin_oe), 16'h00);
        chk("R4 force", 16'(test_force), 16'h1);
        step(); step();
        chk("R6 no strobe", 16'(pl_strobe), 16'h0);
        chk("R6 data held", 16'(pl_data), 16'h00);
        observe_req = 1'b0;
        init_busy = 1'b0;
        step();
        // R5: capture happened at this edge, strobe now
        chk("R5 strobe bank1", 16'(pl_strobe), 16'h2);
        chk("R5 data", 16'(pl_data), 16'h3C);
        chk("R4 oe", 16'(pin_oe), 16'h00);
        pin_in = 8'hC3;
        step();
        chk("R5 single strobe", 16'(pl_strobe), 16'h0);
        chk("R7 data kept", 16'(pl_data), 16'h3C);
        step();
        chk("R7 one strobe", 16'(pl_strobe), 16'h0);
        chk("R7 still test", 16'(test_force), 16'h1);
        preload_req = 1'b0;
        step();
        chk("R7 back normal", 16'(test_force), 16'h0);
        chk("R7 oe config", 16'(pin_oe), 16'hFF);

        // R5: bank 0 preload, no busy wait
        bank_sel = 1'b0; pin_in = 8'hA5; preload_req = 1'b1;
        step();
        chk("R5 arm no strobe", 16'(pl_strobe), 16'h0);
        step();
        chk("R5 strobe bank0", 16'(pl_strobe), 16'h1);
        chk("R5 data bank0", 16'(pl_data), 16'hA5);
        preload_req = 1'b0;
        step(); step();
        chk("R7 normal again", 16'(test_force), 16'h0);

        // R8: observe with all drivers configured off
        oe_cfg = 16'h0000; mc_out = 8'h11; reg_q = 16'h5AC3;
        observe_req = 1'b1; bank_sel = 1'b0;
        step();
        chk("R8 oe on", 16'(pin_oe), 16'hFF);
        chk("R8 output bank", 16'(pin_out), 16'hC3);
        chk("R4 observe force", 16'(test_force), 16'h1);
        bank_sel = 1'b1; #1;
        chk("R8 buried bank", 16'(pin_out), 16'h5A);
        observe_req = 1'b0;
        step();
        chk("R3 after observe", 16'(pin_out), 16'h11);
        chk("R1 after observe", 16'(pin_oe), 16'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule